// File: doc/BRIEF.md
# Predicated Vector Lane ALU

The block performs one integer operation across every element of a wide vector register whose length is fixed when it is built. Two source vectors enter with an element-size code, a 3-bit operation code and a per-byte predicate. The element size is 8, 16, 32 or 64 bits, and elements are packed across the whole vector. Each element computes its own result. The predicate then decides which elements take that result. An element that is not enabled is cleared when the zeroing mode is selected. In merging mode it keeps the old destination value, which arrives on its own input.

A request is accepted in any cycle in which `in_valid` is high. Its result appears one clock later on `result`, with `out_valid` high. A small two-state controller tracks the output: `ST_IDLE` means no fresh result and `ST_RESULT` means a result was captured in the previous cycle. From either state the controller moves to `ST_RESULT` when `in_valid` is high and to `ST_IDLE` when it is low. The `result` register changes only on accepted requests.

Top module: `vec_lane_alu`

## Requirements
- R1: The parameter `VLEN` must be a multiple of 128 in the range 128 to 2048. The predicate input is `VLEN/8` bits wide, with bit i belonging to byte i of the vector.
- R2: `esize` selects the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Element k occupies bits `[k*W +: W]`.
- R3: Opcode 0 computes a+b and opcode 1 computes a-b, both wrapping modulo 2^W.
- R4: Opcode 2 computes bitwise AND, opcode 3 OR and opcode 4 XOR.
- R5: Opcode 5 gives the signed minimum, opcode 6 the unsigned minimum and opcode 7 the unsigned maximum.
- R6: An element is active when the predicate bit of its lowest-numbered byte is 1. The other predicate bits of that element have no effect.
- R7: With `zero_mode`=1, every inactive element of the result is zero.
- R8: With `zero_mode`=0, every inactive element of the result equals the same element of `dst_old`.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` then holds the outcome of that request.
- R10: While `in_valid` is low, `result` holds its value. Reset clears both `result` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation select |
| esize | input | 2 | Element width code |
| zero_mode | input | 1 | 1 clears inactive elements, 0 merges them from `dst_old` |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| dst_old | input | VLEN | Previous destination value, used for merging |
| pred | input | VLEN/8 | Per-byte predicate |
| out_valid | output | 1 | Result-valid strobe |
| result | output | VLEN | Registered result vector |

## Verification
The case hardest to reach from the ports is a wide element whose predicate group holds conflicting bits. Random predicates seldom produce groups in which only the upper bits are set, or only the lowest bit is set. The stimulus therefore adds 64-bit requests with two fixed predicates: one sets every bit except each element's lowest, and the other sets only the lowest bits. Between them they show whether the governing bit decides the element. A full sweep of every element size, opcode and mode uses wrap-around operands and random data. The bench compares each result against a per-element reference computed in 64-bit arithmetic.

// File: rtl/vla_pkg.sv
package vla_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SMIN = 3'd5,
        OP_UMIN = 3'd6,
        OP_UMAX = 3'd7
    } vla_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } vla_state_e;

    localparam int unsigned NUM_SIZES = 4;

endpackage

// File: rtl/vla_elem_unit.sv
module vla_elem_unit
    import vla_pkg::*;
#(
    parameter int unsigned EW = 8
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic [2:0]    op,
    output logic [EW-1:0] y
);

    logic s_lt;
    logic u_lt;

    assign s_lt = ($signed(a) < $signed(b));
    assign u_lt = (a < b);

    always_comb begin
        unique case (vla_op_e'(op))
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SMIN: y = s_lt ? a : b;
            OP_UMIN: y = u_lt ? a : b;
            OP_UMAX: y = u_lt ? b : a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vla_size_slice.sv
module vla_size_slice #(
    parameter int unsigned VLEN = 256,
    parameter int unsigned EW   = 8
) (
    input  logic [VLEN-1:0] a,
    input  logic [VLEN-1:0] b,
    input  logic [2:0]      op,
    output logic [VLEN-1:0] y
);

    localparam int unsigned NUM_EL = VLEN / EW;

    for (genvar k = 0; k < NUM_EL; k++) begin : g_el
        vla_elem_unit #(.EW(EW)) i_unit (
            .a  (a[k*EW +: EW]),
            .b  (b[k*EW +: EW]),
            .op (op),
            .y  (y[k*EW +: EW])
        );
    end

endmodule

// File: rtl/vla_pred_expand.sv
module vla_pred_expand #(
    parameter int unsigned VLEN = 256
) (
    input  logic [VLEN/8-1:0] pred,
    input  logic [1:0]        esize,
    output logic [VLEN/8-1:0] byte_en
);

    localparam int unsigned NB = VLEN / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int unsigned G16 = i & ~1;
        localparam int unsigned G32 = i & ~3;
        localparam int unsigned G64 = i & ~7;
        always_comb begin
            unique case (esize)
                2'd0:    byte_en[i] = pred[i];
                2'd1:    byte_en[i] = pred[G16];
                2'd2:    byte_en[i] = pred[G32];
                default: byte_en[i] = pred[G64];
            endcase
        end
    end

endmodule

// File: rtl/vla_lane_merge.sv
module vla_lane_merge #(
    parameter int unsigned VLEN = 256
) (
    input  logic [VLEN-1:0]   computed,
    input  logic [VLEN-1:0]   dst_old,
    input  logic [VLEN/8-1:0] byte_en,
    input  logic              zero_mode,
    output logic [VLEN-1:0]   merged
);

    localparam int unsigned NB = VLEN / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_comb begin
            if (byte_en[i])
                merged[i*8 +: 8] = computed[i*8 +: 8];
            else if (zero_mode)
                merged[i*8 +: 8] = 8'h00;
            else
                merged[i*8 +: 8] = dst_old[i*8 +: 8];
        end
    end

endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
    import vla_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        opcode,
    input  logic [1:0]        esize,
    input  logic              zero_mode,
    input  logic [VLEN-1:0]   src_a,
    input  logic [VLEN-1:0]   src_b,
    input  logic [VLEN-1:0]   dst_old,
    input  logic [VLEN/8-1:0] pred,
    output logic              out_valid,
    output logic [VLEN-1:0]   result
);

    localparam int unsigned NB = VLEN / 8;

    if ((VLEN % 128) != 0 || VLEN < 128 || VLEN > 2048) begin : g_bad_vlen
        $error("VLEN must be a multiple of 128 between 128 and 2048");
    end

    logic [NUM_SIZES-1:0][VLEN-1:0] by_size;
    logic [VLEN-1:0]                computed;
    logic [VLEN-1:0]                merged;
    logic [NB-1:0]                  byte_en;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        vla_size_slice #(.VLEN(VLEN), .EW(8 << g)) i_slice (
            .a  (src_a),
            .b  (src_b),
            .op (opcode),
            .y  (by_size[g])
        );
    end

    assign computed = by_size[esize];

    vla_pred_expand #(.VLEN(VLEN)) i_pred (
        .pred    (pred),
        .esize   (esize),
        .byte_en (byte_en)
    );

    vla_lane_merge #(.VLEN(VLEN)) i_merge (
        .computed  (computed),
        .dst_old   (dst_old),
        .byte_en   (byte_en),
        .zero_mode (zero_mode),
        .merged    (merged)
    );

    vla_state_e state_q;
    vla_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result <= '0;
        else if (in_valid)
            result <= merged;
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/vla_checker.sv
module vla_checker #(
    parameter int unsigned VLEN = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        opcode,
    input logic [1:0]        esize,
    input logic              zero_mode,
    input logic [VLEN-1:0]   src_a,
    input logic [VLEN-1:0]   src_b,
    input logic [VLEN-1:0]   dst_old,
    input logic [VLEN/8-1:0] pred,
    input logic              out_valid,
    input logic [VLEN-1:0]   result
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R10

    AST_ZERO_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode && !pred[0]) |=> (result[7:0] == 8'h00)); // R7

    AST_MERGE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mode && !pred[0]) |=> (result[7:0] == $past(dst_old[7:0]))); // R8

    AST_BYTE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[0] && opcode == 3'd0 && esize == 2'd0)
        |=> (result[7:0] == 8'($past(src_a[7:0]) + $past(src_b[7:0])))); // R3

    AST_XOR_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[0] && opcode == 3'd4)
        |=> (result[7:0] == ($past(src_a[7:0]) ^ $past(src_b[7:0])))); // R4

endmodule

bind vec_lane_alu vla_checker #(.VLEN(VLEN)) i_vla_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .esize     (esize),
    .zero_mode (zero_mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_old   (dst_old),
    .pred      (pred),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_vec_lane_alu.sv
module test_vec_lane_alu;

    localparam int unsigned VLEN = 256;
    localparam int unsigned NB   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [2:0]      opcode = '0;
    logic [1:0]      esize = '0;
    logic            zero_mode = 1'b0;
    logic [VLEN-1:0] src_a = '0;
    logic [VLEN-1:0] src_b = '0;
    logic [VLEN-1:0] dst_old = '0;
    logic [NB-1:0]   pred = '0;
    logic            out_valid;
    logic [VLEN-1:0] result;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    vec_lane_alu #(.VLEN(VLEN)) i_vec_lane_alu (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .opcode (opcode),
        .esize (esize), .zero_mode (zero_mode), .src_a (src_a), .src_b (src_b),
        .dst_old (dst_old), .pred (pred), .out_valid (out_valid), .result (result)
    );

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    function automatic logic [63:0] ref_elem(logic [63:0] a, logic [63:0] b,
                                             int op, int w);
        logic [63:0]        m;
        logic signed [63:0] sa;
        logic signed [63:0] sb;
        logic [63:0]        r;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        sa = $signed(a << (64 - w)) >>> (64 - w);
        sb = $signed(b << (64 - w)) >>> (64 - w);
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = (sa < sb) ? a : b;
            6: r = (a < b) ? a : b;
            default: r = (a > b) ? a : b;
        endcase
        return r & m;
    endfunction

    function automatic logic [VLEN-1:0] ref_vec(logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                                                logic [VLEN-1:0] d, logic [NB-1:0] p,
                                                int op, int esz, bit zm);
        logic [VLEN-1:0] e;
        int              w;
        logic [63:0]     m;
        logic [63:0]     ea;
        logic [63:0]     eb;
        logic [63:0]     ed;
        logic [63:0]     r;
        e = '0;
        w = 8 << esz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int k = 0; k < VLEN / w; k++) begin
            ea = 64'(a >> (k * w)) & m;
            eb = 64'(b >> (k * w)) & m;
            ed = 64'(d >> (k * w)) & m;
            if (p[k * (w / 8)]) r = ref_elem(ea, eb, op, w);
            else if (zm)        r = '0;
            else                r = ed;
            e = e | (VLEN'(r) << (k * w));
        end
        return e;
    endfunction

    function automatic string op_tag(int op);
        if (op <= 1) return "R3";
        if (op <= 4) return "R4";
        return "R5";
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_one(int op, int esz, bit zm, logic [VLEN-1:0] a,
                           logic [VLEN-1:0] b, logic [VLEN-1:0] d,
                           logic [NB-1:0] p, string extra);
        logic [VLEN-1:0] exp;
        @(negedge clk);
        in_valid  = 1'b1;
        opcode    = 3'(op);
        esize     = 2'(esz);
        zero_mode = zm;
        src_a = a; src_b = b; dst_old = d; pred = p;
        exp = ref_vec(a, b, d, p, op, esz, zm);
        @(negedge clk);
        check_bit("R9 out_valid after request", out_valid, 1'b1);
        check_vec($sformatf("%s %s R2 %s op=%0d esize=%0d", op_tag(op),
                            zm ? "R7" : "R8", extra, op, esz), result, exp);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] held;
        logic [NB-1:0]   pmask;
        repeat (3) @(negedge clk);
        check_bit("R10 out_valid in reset", out_valid, 1'b0);
        check_vec("R10 result in reset", result, '0);
        check_bit("R1 predicate width", ($bits(pred) == VLEN / 8), 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R9 idle out_valid", out_valid, 1'b0);

        for (int esz = 0; esz < 4; esz++)
            for (int op = 0; op < 8; op++)
                for (int zm = 0; zm < 2; zm++) begin
                    run_one(op, esz, bit'(zm), '1, {(VLEN/8){8'h01}}, rand_vec(),
                            NB'(rand_vec()), "wrap-high");
                    run_one(op, esz, bit'(zm), '0, {(VLEN/8){8'h80}}, rand_vec(),
                            NB'(rand_vec()), "wrap-low");
                    for (int r = 0; r < 4; r++)
                        run_one(op, esz, bit'(zm), rand_vec(), rand_vec(), rand_vec(),
                                NB'(rand_vec()), "random");
                end

        pmask = '0;
        for (int i = 0; i < NB; i += 8) pmask[i] = 1'b1;
        run_one(0, 3, 1'b1, rand_vec(), rand_vec(), rand_vec(), ~pmask,
                "R6 upper bits only");
        check_vec("R6 upper-bit-only group is inactive", result, '0);
        run_one(4, 3, 1'b0, rand_vec(), rand_vec(), rand_vec(), pmask,
                "R6 lowest bit only");
        pmask = '0;
        for (int i = 0; i < NB; i += 4) pmask[i] = 1'b1;
        run_one(1, 2, 1'b0, rand_vec(), rand_vec(), rand_vec(), pmask,
                "R6 32-bit lowest bits");

        run_one(7, 1, 1'b1, rand_vec(), rand_vec(), rand_vec(), '1, "R10 setup");
        held = result;
        @(negedge clk);
        src_a = rand_vec(); src_b = rand_vec(); dst_old = rand_vec();
        pred = NB'(rand_vec()); opcode = 3'd1; zero_mode = 1'b0;
        @(negedge clk);
        check_bit("R9 out_valid low without request", out_valid, 1'b0);
        check_vec("R10 result held without request", result, held);
        @(negedge clk);
        check_vec("R10 result still held", result, held);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule